// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Write Inhibit

This block is a clocked true dual-port memory of 2048 words by 16 bits. A left port and a right port each carry their own address, active-low chip enable, active-low output enable, write data, read data and a pair of active-low per-lane write strobes. Each byte lane of a port decides for itself, in every access, whether it writes its byte or reads the stored byte out. One port can therefore update the lower byte of a word while fetching the upper byte of that same word in a single access.

Each port also has an active-low busy input. When busy is low, the port's writes are dropped inside the block, but its reads still go ahead. Arbitration that drives busy comes from elsewhere. Holding busy low turns a port into a read-only port, and holding it high gives plain operation. The lane output drivers of the pins are replaced by one valid flag per lane. Read data for a lane is forced to zero whenever that lane's flag is clear.

Every lane of every port runs a small state register that holds the action it took at the last edge. The states are LA_STANDBY (chip enable high), LA_WRITE (strobe low, busy high), LA_INHIBIT (strobe low, busy low), LA_READ (strobe high, output enable low) and LA_MUTE (strobe high, output enable high). There are no sticky transitions. At each rising edge a lane moves from any state to the state decoded from that cycle's inputs, and the lane's valid flag is set only in LA_READ.

Top module: `byte_lane_dpram`

## Requirements
- R1: The array holds 2048 words of 16 bits on 11-bit addresses, and a word written through either port can be read through the other port at any address, including 0 and 2047.
- R2: When a port's chip enable is high at a rising edge, that port writes nothing, and both of its valid flags are 0 after that edge.
- R3: With chip enable low and busy high, a lane whose strobe is low stores its data byte into the addressed word at the edge. Strobe bit 0 controls data bits 7:0 and strobe bit 1 controls bits 15:8. The other lane of the word keeps its value, and a writing lane's valid flag is 0 after the edge.
- R4: With chip enable low, a lane whose strobe is high and output enable low sets its valid flag after the edge, and presents the addressed byte as it was stored before that edge.
- R5: When output enable is high, no lane of that port sets its valid flag, whatever its strobe.
- R6: In one access a port can write one lane and read the other lane of the same word, and the read lane returns the value stored before the access.
- R7: When a port's busy input is low, none of its lanes changes the memory, its writing lanes report valid 0, and its reading lanes still return the stored data.
- R8: The read data byte of every lane is zero whenever that lane's valid flag is 0.
- R9: When both ports write the same lane of the same word at one edge and neither is blocked, the left port's byte is stored.
- R10: During and right after reset, all valid flags and all read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Active-low reset of state and read registers (not the array) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_n | input | 2 | Left per-lane write strobes, active low; bit 0 lower byte, bit 1 upper byte |
| l_busy_n | input | 1 | Left write inhibit, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, zero in lanes that are not valid |
| l_rvalid | output | 2 | Left per-lane read valid flags |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_n | input | 2 | Right per-lane write strobes, active low; bit 0 lower byte, bit 1 upper byte |
| r_busy_n | input | 1 | Right write inhibit, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, zero in lanes that are not valid |
| r_rvalid | output | 2 | Right per-lane read valid flags |

## Verification
Every result of this block is due one edge after its access is sampled. The valid flags and the read bytes are both registered, and memory writes become visible to reads from the following edge on. The bench applies an access at a falling edge and computes the expected flags and bytes from its reference array before committing that access's writes to the array. It then lets one rising edge pass and compares at the next falling edge, so each comparison sits half a cycle from both edges. Random traffic keeps the two port addresses apart so that no read depends on a same-word collision. Directed cases cover the collision and write-priority paths.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [2:0] {
        LA_STANDBY,
        LA_WRITE,
        LA_INHIBIT,
        LA_READ,
        LA_MUTE
    } lane_act_e;

    function automatic lane_act_e decode_lane(
        input logic ce_n,
        input logic oe_n,
        input logic wr_n,
        input logic busy_n
    );
        if (ce_n)
            return LA_STANDBY;
        else if (!wr_n)
            return busy_n ? LA_WRITE : LA_INHIBIT;
        else
            return oe_n ? LA_MUTE : LA_READ;
    endfunction

endpackage

// File: rtl/dpram_lane_ctrl.sv
module dpram_lane_ctrl
    import dpram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] wr_n,
    input  logic             busy_n,
    output logic [LANES-1:0] wr_en,
    output logic [LANES-1:0] rd_valid
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_act_e act_d;
        lane_act_e st_q;
        logic      wen_k;
        logic      rv_k;

        // next state: decoded action of this lane for the current access
        always_comb begin
            act_d = decode_lane(ce_n, oe_n, wr_n[k], busy_n);
        end

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                st_q <= LA_STANDBY;
            else
                st_q <= act_d;
        end

        // outputs
        always_comb begin
            wen_k = 1'b0;
            rv_k  = 1'b0;
            unique case (act_d)
                LA_WRITE:   wen_k = 1'b1;
                LA_STANDBY,
                LA_INHIBIT,
                LA_READ,
                LA_MUTE:    wen_k = 1'b0;
                default:    wen_k = 1'b0;
            endcase
            unique case (st_q)
                LA_READ:    rv_k = 1'b1;
                LA_STANDBY,
                LA_WRITE,
                LA_INHIBIT,
                LA_MUTE:    rv_k = 1'b0;
                default:    rv_k = 1'b0;
            endcase
        end

        assign wr_en[k]    = wen_k;
        assign rd_valid[k] = rv_k;
    end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int AW    = 11,
    parameter int LW    = 8,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       l_addr,
    input  logic [LANES-1:0]    l_wen,
    input  logic [LANES*LW-1:0] l_wdata,
    output logic [LANES*LW-1:0] l_word,
    input  logic [AW-1:0]       r_addr,
    input  logic [LANES-1:0]    r_wen,
    input  logic [LANES*LW-1:0] r_wdata,
    output logic [LANES*LW-1:0] r_word
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LW;

    logic [DW-1:0] mem [DEPTH];

    // right lanes first, left lanes last: left wins on a same-lane clash
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (r_wen[k])
                mem[r_addr][k*LW +: LW] <= r_wdata[k*LW +: LW];
        end
        for (int k = 0; k < LANES; k++) begin
            if (l_wen[k])
                mem[l_addr][k*LW +: LW] <= l_wdata[k*LW +: LW];
        end
    end

    // registered read of the word as stored before this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_word <= '0;
            r_word <= '0;
        end else begin
            l_word <= mem[l_addr];
            r_word <= mem[r_addr];
        end
    end

endmodule

// File: rtl/byte_lane_dpram.sv
module byte_lane_dpram #(
    parameter int AW    = 11,
    parameter int LW    = 8,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                l_ce_n,
    input  logic                l_oe_n,
    input  logic [LANES-1:0]    l_wr_n,
    input  logic                l_busy_n,
    input  logic [AW-1:0]       l_addr,
    input  logic [LANES*LW-1:0] l_wdata,
    output logic [LANES*LW-1:0] l_rdata,
    output logic [LANES-1:0]    l_rvalid,
    input  logic                r_ce_n,
    input  logic                r_oe_n,
    input  logic [LANES-1:0]    r_wr_n,
    input  logic                r_busy_n,
    input  logic [AW-1:0]       r_addr,
    input  logic [LANES*LW-1:0] r_wdata,
    output logic [LANES*LW-1:0] r_rdata,
    output logic [LANES-1:0]    r_rvalid
);

    localparam int DW = LANES * LW;

    logic [LANES-1:0] l_wen;
    logic [LANES-1:0] r_wen;
    logic [DW-1:0]    l_word;
    logic [DW-1:0]    r_word;

    dpram_lane_ctrl #(.LANES(LANES)) u_lctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (l_ce_n),
        .oe_n     (l_oe_n),
        .wr_n     (l_wr_n),
        .busy_n   (l_busy_n),
        .wr_en    (l_wen),
        .rd_valid (l_rvalid)
    );

    dpram_lane_ctrl #(.LANES(LANES)) u_rctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (r_ce_n),
        .oe_n     (r_oe_n),
        .wr_n     (r_wr_n),
        .busy_n   (r_busy_n),
        .wr_en    (r_wen),
        .rd_valid (r_rvalid)
    );

    dpram_store #(.AW(AW), .LW(LW), .LANES(LANES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_addr  (l_addr),
        .l_wen   (l_wen),
        .l_wdata (l_wdata),
        .l_word  (l_word),
        .r_addr  (r_addr),
        .r_wen   (r_wen),
        .r_wdata (r_wdata),
        .r_word  (r_word)
    );

    // lanes that are not valid present zero instead of a floating bus
    for (genvar k = 0; k < LANES; k++) begin : g_mask
        assign l_rdata[k*LW +: LW] = l_rvalid[k] ? l_word[k*LW +: LW] : '0;
        assign r_rdata[k*LW +: LW] = r_rvalid[k] ? r_word[k*LW +: LW] : '0;
    end

endmodule

// File: rtl/dpram_checker.sv
module dpram_checker #(
    parameter int LW    = 8,
    parameter int LANES = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                l_ce_n,
    input logic                l_oe_n,
    input logic [LANES-1:0]    l_wr_n,
    input logic [LANES*LW-1:0] l_rdata,
    input logic [LANES-1:0]    l_rvalid,
    input logic                r_ce_n,
    input logic                r_oe_n,
    input logic [LANES-1:0]    r_wr_n,
    input logic [LANES*LW-1:0] r_rdata,
    input logic [LANES-1:0]    r_rvalid
);

    assert_standby_quiet_l_R2: assert property (@(posedge clk) disable iff (!rst_n)
        l_ce_n |=> (l_rvalid == '0));
    assert_standby_quiet_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_ce_n |=> (r_rvalid == '0));
    assert_oe_mute_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |=> (l_rvalid == '0));
    assert_oe_mute_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_oe_n |=> (r_rvalid == '0));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assert_write_quiet_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!l_ce_n && !l_wr_n[k]) |=> !l_rvalid[k]);
        assert_write_quiet_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_ce_n && !r_wr_n[k]) |=> !r_rvalid[k]);
        assert_read_valid_l_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!l_ce_n && l_wr_n[k] && !l_oe_n) |=> l_rvalid[k]);
        assert_read_valid_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_ce_n && r_wr_n[k] && !r_oe_n) |=> r_rvalid[k]);
        assert_idle_zero_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !l_rvalid[k] |-> (l_rdata[k*LW +: LW] == '0));
        assert_idle_zero_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !r_rvalid[k] |-> (r_rdata[k*LW +: LW] == '0));
    end

endmodule

bind byte_lane_dpram dpram_checker #(.LW(LW), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_ce_n   (l_ce_n),
    .l_oe_n   (l_oe_n),
    .l_wr_n   (l_wr_n),
    .l_rdata  (l_rdata),
    .l_rvalid (l_rvalid),
    .r_ce_n   (r_ce_n),
    .r_oe_n   (r_oe_n),
    .r_wr_n   (r_wr_n),
    .r_rdata  (r_rdata),
    .r_rvalid (r_rvalid)
);

// File: tb/tb_byte_lane_dpram.sv
`timescale 1ns/1ps
module tb_byte_lane_dpram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_ce_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
    logic [1:0]  l_wr_n = 2'b11;
    logic [10:0] l_addr = '0;
    logic [15:0] l_wdata = '0;
    logic [15:0] l_rdata;
    logic [1:0]  l_rvalid;
    logic        r_ce_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
    logic [1:0]  r_wr_n = 2'b11;
    logic [10:0] r_addr = '0;
    logic [15:0] r_wdata = '0;
    logic [15:0] r_rdata;
    logic [1:0]  r_rvalid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] mdl [2048];

    always #2 clk = ~clk;

    byte_lane_dpram dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_busy_n(l_busy_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_busy_n(r_busy_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string lane_tag(input logic ce_n, input logic oe_n, input logic wr_n, input logic busy_n);
        if (ce_n) return "R2";
        if (!wr_n) return busy_n ? "R3" : "R7";
        return oe_n ? "R5" : "R4";
    endfunction

    // one access on both ports; expected results taken from the model before the writes
    task automatic step(input string force_tag);
        logic [1:0]  ev_l, ev_r;
        logic [15:0] ed_l, ed_r;
        string       tg_l [2];
        string       tg_r [2];
        for (int k = 0; k < 2; k++) begin
            ev_l[k] = !l_ce_n && l_wr_n[k] && !l_oe_n;
            ev_r[k] = !r_ce_n && r_wr_n[k] && !r_oe_n;
            ed_l[k*8 +: 8] = ev_l[k] ? mdl[l_addr][k*8 +: 8] : 8'h00;
            ed_r[k*8 +: 8] = ev_r[k] ? mdl[r_addr][k*8 +: 8] : 8'h00;
            tg_l[k] = (force_tag != "") ? force_tag : lane_tag(l_ce_n, l_oe_n, l_wr_n[k], l_busy_n);
            tg_r[k] = (force_tag != "") ? force_tag : lane_tag(r_ce_n, r_oe_n, r_wr_n[k], r_busy_n);
        end
        for (int k = 0; k < 2; k++)
            if (!r_ce_n && !r_wr_n[k] && r_busy_n) mdl[r_addr][k*8 +: 8] = r_wdata[k*8 +: 8];
        for (int k = 0; k < 2; k++)
            if (!l_ce_n && !l_wr_n[k] && l_busy_n) mdl[l_addr][k*8 +: 8] = l_wdata[k*8 +: 8];
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(tg_l[k], $sformatf("left valid lane%0d", k), {15'd0, l_rvalid[k]}, {15'd0, ev_l[k]});
            chk(ev_l[k] ? tg_l[k] : "R8", $sformatf("left data lane%0d", k), {8'd0, l_rdata[k*8 +: 8]}, {8'd0, ed_l[k*8 +: 8]});
            chk(tg_r[k], $sformatf("right valid lane%0d", k), {15'd0, r_rvalid[k]}, {15'd0, ev_r[k]});
            chk(ev_r[k] ? tg_r[k] : "R8", $sformatf("right data lane%0d", k), {8'd0, r_rdata[k*8 +: 8]}, {8'd0, ed_r[k*8 +: 8]});
        end
    endtask

    task automatic idle_ports();
        l_ce_n = 1'b1; l_oe_n = 1'b1; l_wr_n = 2'b11; l_busy_n = 1'b1;
        r_ce_n = 1'b1; r_oe_n = 1'b1; r_wr_n = 2'b11; r_busy_n = 1'b1;
    endtask

    task automatic read_l(input logic [10:0] a);
        l_ce_n = 1'b0; l_oe_n = 1'b0; l_wr_n = 2'b11; l_addr = a;
    endtask

    task automatic read_r(input logic [10:0] a);
        r_ce_n = 1'b0; r_oe_n = 1'b0; r_wr_n = 2'b11; r_addr = a;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "left valid in reset", {14'd0, l_rvalid}, 16'd0);
        chk("R10", "left data in reset", l_rdata, 16'd0);
        chk("R10", "right valid in reset", {14'd0, r_rvalid}, 16'd0);
        chk("R10", "right data in reset", r_rdata, 16'd0);
        rst_n = 1'b1;
        step("R10");

        // fill the array: left fills the lower half, right the upper half
        for (int i = 0; i < 1024; i++) begin
            l_ce_n = 1'b0; l_oe_n = 1'b1; l_wr_n = 2'b00; l_addr = 11'(i);
            l_wdata = 16'(i * 40503) ^ 16'h5A5A;
            r_ce_n = 1'b0; r_oe_n = 1'b1; r_wr_n = 2'b00; r_addr = 11'(i + 1024);
            r_wdata = 16'((i + 1024) * 40503) ^ 16'hC3C3;
            step("");
        end

        // R1: cross-port reads, both address ends
        idle_ports();
        read_l(11'd2047); read_r(11'd0);
        step("R1");
        read_l(11'd1500); read_r(11'd3);
        step("R1");

        // R6: left writes lower, reads upper of word 5
        idle_ports();
        l_ce_n = 1'b0; l_oe_n = 1'b0; l_wr_n = 2'b10; l_addr = 11'd5; l_wdata = 16'hBEEF;
        step("R6");
        idle_ports(); read_l(11'd5);
        step("R6");

        // R3: upper lane only, right port
        idle_ports();
        r_ce_n = 1'b0; r_oe_n = 1'b1; r_wr_n = 2'b01; r_addr = 11'd10; r_wdata = 16'hA55A;
        step("R3");
        idle_ports(); read_r(11'd10);
        step("R3");

        // R7: right blocked, writes both lanes with oe low
        idle_ports();
        r_ce_n = 1'b0; r_oe_n = 1'b0; r_wr_n = 2'b00; r_busy_n = 1'b0; r_addr = 11'd7; r_wdata = 16'h1234;
        step("R7");
        r_wr_n = 2'b11;
        step("R7");
        idle_ports(); read_r(11'd7);
        step("R7");

        // R2: chip enable high with strobes low changes nothing
        idle_ports();
        l_wr_n = 2'b00; l_oe_n = 1'b0; l_addr = 11'd12; l_wdata = 16'hFFFF;
        step("R2");
        idle_ports(); read_l(11'd12);
        step("R2");

        // R5: strobes high, output enable high
        idle_ports();
        l_ce_n = 1'b0; l_addr = 11'd12; r_ce_n = 1'b0; r_addr = 11'd13;
        step("R5");

        // R9: same-word write from both ports, left wins
        idle_ports();
        l_ce_n = 1'b0; l_wr_n = 2'b00; l_addr = 11'd9; l_wdata = 16'h1111;
        r_ce_n = 1'b0; r_wr_n = 2'b00; r_addr = 11'd9; r_wdata = 16'h2222;
        step("R9");
        idle_ports(); read_l(11'd9); read_r(11'd9);
        step("R9");

        // random traffic, port addresses kept apart
        for (int n = 0; n < 3000; n++) begin
            l_ce_n = ($urandom % 5) == 0;
            l_oe_n = ($urandom % 4) == 0;
            l_wr_n = 2'($urandom);
            l_busy_n = ($urandom % 6) != 0;
            l_addr = (($urandom % 8) == 0) ? 11'($urandom) : 11'($urandom % 32);
            l_wdata = 16'($urandom);
            r_ce_n = ($urandom % 5) == 0;
            r_oe_n = ($urandom % 4) == 0;
            r_wr_n = 2'($urandom);
            r_busy_n = ($urandom % 6) != 0;
            r_addr = (($urandom % 8) == 0) ? 11'($urandom) : 11'($urandom % 32);
            r_wdata = 16'($urandom);
            if (r_addr == l_addr) r_addr = l_addr ^ 11'd1;
            step("");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule